// File: doc/BRIEF.md
# Fractional Display Clock Divider

The block turns a reference clock into a slower display clock whose average period is a programmable fixed-point multiple of the reference period. The divide value is 17 bits wide: 9 integer bits above 8 fraction bits, so one raw unit is 1/256 of a reference cycle. Fractions are realised by dithering. A phase accumulator gains a fixed step each reference cycle and toggles the output each time it reaches the programmed value. The remainder is kept, so the long-run average period is exact, while a single period may be one cycle longer or shorter.

Software programs the divide value and then sets the enable. The value can come from a measured ratio between reference and capture clocks, which lets the display clock follow the capture clock. A new value written while running is picked up at the next period boundary. Clearing the enable, or a value that is too small, stops the output at once and leaves it low. Besides the divided clock, the block gives a one-cycle strobe in the reference domain that marks each rising edge of the divided clock.

Top module: `frac_dclk_div`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it, `dclk_o` and `rise_o` are 0 and the block is stopped.
- R2: `div_i` is unsigned 9.8 fixed point (bits 16..8 integer, bits 7..0 fraction). When `en_i` is 1 and the value is valid while the block is stopped, the block latches `div_i`, clears its accumulator and holds `dclk_o` low in the following cycle.
- R3: While running, the accumulator gains 512 raw units (half a period step) per reference cycle. Each time the sum reaches the latched value, the value is subtracted, the remainder is kept and `dclk_o` toggles. The average output period is therefore `div_i`/256 reference cycles.
- R4: A value of exactly 2.0 (raw 512) toggles `dclk_o` on every reference cycle, which gives a divide-by-two clock with 50% duty.
- R5: A value below 2.0 (raw < 512) is invalid. With such a value, `dclk_o` stays low, `rise_o` stays 0 and the accumulator stays cleared.
- R6: When `en_i` is 0 at a clock edge, `dclk_o` and `rise_o` are 0 after that edge. The next enable restarts the accumulator from zero.
- R7: A change of `div_i` while running takes effect only at the next falling edge of `dclk_o`, which is the period boundary. Toggles before that edge use the previous value.
- R8: `rise_o` is 1 for exactly one reference cycle, namely the first cycle in which `dclk_o` reads 1 after a 0.
- R9: If `div_i` becomes invalid while running, the block stops at the next edge in the same way as a cleared enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Generation enable |
| div_i | input | 17 | Divide value, 9.8 fixed point |
| dclk_o | output | 1 | Divided display clock |
| rise_o | output | 1 | One-cycle strobe on each rising edge of dclk_o |

## Verification
On every cycle the assertions check the following. The accumulator residue stays below the latched value. The rise strobe only appears with a fresh 0-to-1 step of the output. The output is low after a cleared enable or an invalid value. The latched value changes only on a falling edge or at a start.

Some behaviours can only be shown by the bench's scenarios against its behavioural model:
- the exact toggle cycle sequence for integer, fractional and extreme values;
- the long-run edge counts that prove the average period;
- the deferred pick-up of a value changed mid-period.

// File: rtl/frac_dclk_pkg.sv
// Package: shared widths and helpers for the fractional display clock divider.
// Assumes the divide value is unsigned fixed point, integer bits above fraction bits.
package frac_dclk_pkg;
    localparam int INT_W  = 9;
    localparam int FRAC_W = 8;
    localparam int DIV_W  = INT_W + FRAC_W;
    localparam int ACC_W  = DIV_W + 1;
    // Half a period per reference cycle: 2.0 in fixed point
    localparam int HALF_STEP = 2 << FRAC_W;
    // Smallest legal divide value: 2.0 in fixed point
    localparam int MIN_RAW   = 2 << FRAC_W;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [ACC_W-1:0] acc_t;

    // True when the value gives at least one reference cycle per half period
    function automatic logic div_ok(input div_t v);
        return v >= div_t'(MIN_RAW);
    endfunction
endpackage

// File: rtl/frac_dclk_ctrl.sv
// Run control: decides start and stop, and latches the divide value.
// Assumes half_tick comes from the accumulator and dclk_q is the current output level.
module frac_dclk_ctrl
    import frac_dclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  div_t div_i,
    input  logic half_tick,
    input  logic dclk_q,
    output logic keep_run,
    output logic start,
    output logic run_q,
    output div_t per_q
);
    logic boundary;

    // Run condition is evaluated live every cycle
    always_comb keep_run = en_i && div_ok(div_i);
    // A start is a run request while stopped
    always_comb start = keep_run && !run_q;
    // The period ends when the high phase toggles back to low
    always_comb boundary = half_tick && dclk_q;

    // Run flag register
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= keep_run;
    end

    // Divide value latch: loaded at start and at period boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)                       per_q <= '0;
        else if (start)                   per_q <= div_i;
        else if (keep_run && boundary)    per_q <= div_i;
    end

    AST_PER_LATCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$stable(per_q)) |-> $past(dclk_q) && !dclk_q) else $error("per changed mid-period"); // R7
    AST_PER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> per_q >= div_t'(MIN_RAW)) else $error("invalid latched value"); // R5
endmodule

// File: rtl/frac_dclk_acc.sv
// Phase accumulator: adds a half-period step per cycle and signals each half-period.
// Assumes per_q is at least HALF_STEP whenever run_q is set.
module frac_dclk_acc
    import frac_dclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic keep_run,
    input  logic start,
    input  logic run_q,
    input  div_t per_q,
    output logic half_tick
);
    acc_t acc_q;
    acc_t sum;
    acc_t per_ext;

    // Candidate phase after this cycle's step
    always_comb begin
        per_ext   = acc_t'(per_q);
        sum       = acc_q + acc_t'(HALF_STEP);
        half_tick = run_q && keep_run && (sum >= per_ext);
    end

    // Accumulator register: cleared when stopped or starting, residue kept on wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                       acc_q <= '0;
        else if (!keep_run || start)      acc_q <= '0;
        else if (half_tick)               acc_q <= sum - per_ext;
        else                              acc_q <= sum;
    end

    AST_ACC_BELOW_PER: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> acc_q < per_ext) else $error("accumulator overflow"); // R3
    AST_ACC_CLEAR_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> acc_q == '0) else $error("accumulator not cleared"); // R6
endmodule

// File: rtl/frac_dclk_out.sv
// Output stage: holds the divided clock level and the rising-edge strobe.
// Assumes half_tick is only raised while running.
module frac_dclk_out (
    input  logic clk,
    input  logic rst_n,
    input  logic keep_run,
    input  logic start,
    input  logic half_tick,
    output logic dclk_q,
    output logic rise_q
);
    // Output level and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n || !keep_run || start) begin
            dclk_q <= 1'b0;
            rise_q <= 1'b0;
        end else if (half_tick) begin
            dclk_q <= !dclk_q;
            rise_q <= !dclk_q;
        end else begin
            rise_q <= 1'b0;
        end
    end

    AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> dclk_q && !$past(dclk_q)) else $error("strobe without edge"); // R8
    AST_EDGE_HAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_q && !$past(dclk_q)) |-> rise_q) else $error("edge without strobe"); // R8
endmodule

// File: rtl/frac_dclk_div.sv
// Top: fractional display clock divider built from control, accumulator and output stage.
// Assumes div_i and en_i are synchronous to clk.
module frac_dclk_div
    import frac_dclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             dclk_o,
    output logic             rise_o
);
    logic keep_run, start, run_q, half_tick, dclk_q, rise_q;
    div_t per_q;

    frac_dclk_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i),
        .half_tick(half_tick), .dclk_q(dclk_q),
        .keep_run(keep_run), .start(start), .run_q(run_q), .per_q(per_q)
    );

    frac_dclk_acc u_acc (
        .clk(clk), .rst_n(rst_n), .keep_run(keep_run), .start(start),
        .run_q(run_q), .per_q(per_q), .half_tick(half_tick)
    );

    frac_dclk_out u_out (
        .clk(clk), .rst_n(rst_n), .keep_run(keep_run), .start(start),
        .half_tick(half_tick), .dclk_q(dclk_q), .rise_q(rise_q)
    );

    // Drive ports from the output stage
    always_comb begin
        dclk_o = dclk_q;
        rise_o = rise_q;
    end

    AST_LOW_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !dclk_o && !rise_o) else $error("output active while disabled"); // R6
    AST_LOW_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_i) < DIV_W'(MIN_RAW)) |-> !dclk_o) else $error("output active on invalid value"); // R5
endmodule

// File: tb/frac_dclk_div_tb_top.sv
module frac_dclk_div_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [16:0] div_i = '0;
    logic        dclk_o, rise_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    int rise_cnt = 0;

    // behavioural reference state
    int  m_acc = 0;
    int  m_per = 0;
    bit  m_run = 0;
    bit  m_dclk = 0;
    bit  m_rise = 0;

    always #10 clk = ~clk;

    frac_dclk_div dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i),
        .dclk_o(dclk_o), .rise_o(rise_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, stepped at each rising edge
    always @(posedge clk) begin
        int dv;
        dv = int'(div_i);
        if (!rst_n || !en_i || dv < 512) begin
            m_run = 0; m_acc = 0; m_dclk = 0; m_rise = 0;
            if (!rst_n) m_per = 0;
        end else if (!m_run) begin
            m_run = 1; m_acc = 0; m_dclk = 0; m_rise = 0; m_per = dv;
        end else begin
            int s;
            s = m_acc + 512;
            if (s >= m_per) begin
                m_acc = s - m_per;
                m_rise = !m_dclk;
                if (m_dclk) m_per = dv;
                m_dclk = !m_dclk;
            end else begin
                m_acc = s;
                m_rise = 0;
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(dclk_o == m_dclk, {cur_req, " dclk"}, int'(dclk_o), int'(m_dclk));
            chk(rise_o == m_rise, {cur_req, " rise"}, int'(rise_o), int'(m_rise));
        end
        if (rise_o) rise_cnt++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cmp_on = 1'b1;
        cur_req = "R1";
        en_i = 1'b1; div_i = 17'd768;
        cyc(3);
        chk(dclk_o == 0 && rise_o == 0, "R1 reset outputs", int'(dclk_o), 0);
        en_i = 1'b0;
        rst_n = 1'b1;
        cyc(1);
        chk(dclk_o == 0, "R1 after reset", int'(dclk_o), 0);

        // R2: start with integer value 3.0, first cycle low
        cur_req = "R2";
        en_i = 1'b1; div_i = 17'd768;
        cyc(1);
        chk(dclk_o == 0, "R2 low after start", int'(dclk_o), 0);
        cyc(60);

        // R4: divide by two
        cur_req = "R4";
        en_i = 1'b0; cyc(1);
        en_i = 1'b1; div_i = 17'd512;
        cyc(2);
        begin
            bit prev;
            prev = dclk_o;
            for (int i = 0; i < 10; i++) begin
                cyc(1);
                chk(dclk_o != prev, "R4 toggle each cycle", int'(dclk_o), int'(!prev));
                prev = dclk_o;
            end
        end

        // R3: fractional 2.5 average
        cur_req = "R3";
        en_i = 1'b0; div_i = 17'd640; cyc(1);
        en_i = 1'b1; cyc(1);
        rise_cnt = 0;
        cyc(1000);
        chk(rise_cnt >= 399 && rise_cnt <= 401, "R3 avg 2.5", rise_cnt, 400);

        // R3: value 2.0 + 1/256
        en_i = 1'b0; div_i = 17'd513; cyc(1);
        en_i = 1'b1; cyc(1);
        rise_cnt = 0;
        cyc(2052);
        chk(rise_cnt >= 1023 && rise_cnt <= 1025, "R3 avg 513/256", rise_cnt, 1024);

        // R3: largest value
        en_i = 1'b0; div_i = 17'h1FFFF; cyc(1);
        en_i = 1'b1; cyc(1100);

        // R7: value change mid period, applied at falling edge
        cur_req = "R7";
        en_i = 1'b0; div_i = 17'd1024; cyc(1);
        en_i = 1'b1; cyc(3);
        div_i = 17'd1536;
        cyc(40);
        div_i = 17'd600;
        cyc(37);

        // R5: invalid value held low
        cur_req = "R5";
        en_i = 1'b0; cyc(1);
        en_i = 1'b1; div_i = 17'd511;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            chk(dclk_o == 0 && rise_o == 0, "R5 invalid low", int'(dclk_o), 0);
        end

        // R9: invalid value while running stops at once
        cur_req = "R9";
        div_i = 17'd768; cyc(5);
        while (!dclk_o) cyc(1);
        div_i = 17'd100;
        cyc(1);
        chk(dclk_o == 0, "R9 stop on invalid", int'(dclk_o), 0);
        div_i = 17'd896; cyc(30);

        // R6: enable cleared mid high phase
        cur_req = "R6";
        while (!dclk_o) cyc(1);
        en_i = 1'b0;
        cyc(1);
        chk(dclk_o == 0 && rise_o == 0, "R6 low on disable", int'(dclk_o), 0);
        cyc(5);
        en_i = 1'b1; cyc(40);

        // R8: strobe already compared each cycle; one explicit check
        cur_req = "R8";
        while (!rise_o) cyc(1);
        chk(dclk_o == 1, "R8 strobe with high", int'(dclk_o), 1);
        cyc(1);
        chk(rise_o == 0, "R8 single cycle", int'(rise_o), 0);

        done = 1'b1;
        finish_run();
    end
endmodule